// File: doc/BRIEF.md
# Serial Flash Sector Lock Controller

This block is the command slave of a serial flash that keeps a small lock register for every sector. It receives single-bit SPI frames in mode 0, sampling data on the rising edge of SCK and driving it on the falling edge. It recognises three commands: set the write enable latch, write a sector's lock register, and read a sector's lock register. Each lock register has two live bits. One is a write lock that blocks program and erase. The other is a lock-down bit that, once set, freezes both bits until the next reset.

A program/erase engine elsewhere on the chip reads one inhibit flag per sector from this block. While that engine runs a cycle, it raises a busy input, and lock writes are refused during that time. The SPI pins are sampled by the block's own system clock through a short synchroniser. A frame ends when chip select goes high. The pending write is committed, or dropped, at that moment.

Top module: `sector_lock_ctrl`

## Requirements
- R1: After reset every sector's write lock and lock-down bits are 0, all inhibit flags are 0, the write enable latch is 0 and the data-out enable is 0.
- R2: A frame made of exactly the 8 bits of the write-enable opcode (default 8'h06), followed by chip select going high, sets the write enable latch.
- R3: A write-lock frame is the opcode (default 8'hE5), then 24 address bits MSB first, then one data byte MSB first. When the latch is set, chip select rises after exactly 40 bits, busy is low and the sector has no lock-down, the frame stores data bit 0 as the write lock and data bit 1 as the lock-down bit. Any write accepted in this way clears the latch.
- R4: If chip select rises after fewer or more than 40 bits of a write-lock frame, no lock bit changes and the latch keeps its value.
- R5: A write-lock frame sent while the latch is 0 changes no lock bit.
- R6: If busy is high when chip select rises, a write-lock frame changes no lock bit and leaves the latch unchanged.
- R7: Once a sector's lock-down bit is 1, later lock writes to that sector change neither of its bits. Only reset clears lock-down.
- R8: The sector is selected by address bits 21:16. Address bits 23 and 22 have no effect.
- R9: The inhibit output of sector i equals that sector's write lock bit.
- R10: A read-lock frame is the opcode (default 8'hE8) followed by 24 address bits. The data-out enable stays 0 for the first 32 SCK periods. After that the byte {6'b0, lock-down, write lock} is driven MSB first, with each bit changing on the falling edge of SCK.
- R11: If a read frame goes on past 8 data bits, the same lock byte is sent again.
- R12: An unknown opcode leaves the latch and lock bits unchanged and never enables data-out.
- R13: When chip select goes high, the current frame ends and data-out is disabled. The next frame is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for spi_miso; 0 means high impedance |
| pe_busy | input | 1 | High while a program or erase cycle is in progress |
| wel | output | 1 | Write enable latch |
| pe_inhibit | output | NUM_SECT | Per-sector program/erase inhibit |

## Verification
Each SPI pin passes through two synchroniser flops before its edge is detected. The latch and the lock bits therefore change on the third system clock edge after chip select rises, and a data-out bit settles on the third edge after SCK falls. The bench holds each SCK half period for six system clocks. A monitor samples data-out only at rising SCK edges, where every bit has had time to settle. Latch and inhibit values are compared ten clocks after chip select rises, well after any commit has landed. Expected read bytes are queued by the driver and popped by the monitor as each byte is completed.

// File: rtl/slk_pkg.sv
package slk_pkg;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_WREN,
    CMD_WRLR,
    CMD_RDLR,
    CMD_OTHER
  } cmd_e;

  localparam int OPC_BITS  = 8;
  localparam int ADDR_BITS = 24;
  localparam int HDR_BITS  = OPC_BITS + ADDR_BITS;
  localparam int FRAME_WR  = HDR_BITS + 8;

endpackage

// File: rtl/slk_pin_sync.sv
module slk_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_high,
  output logic cs_rise,
  output logic mosi_s
);

  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] PIN_IDLE = 3'b100;

  logic [STAGES-1:0][NPIN-1:0] stg_q, stg_d;
  logic [NPIN-1:0]             prev_q, cur;

  assign cur = stg_q[STAGES-1];

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], {cs_n, sck, mosi}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= {STAGES{PIN_IDLE}};
      prev_q <= PIN_IDLE;
    end else begin
      stg_q  <= stg_d;
      prev_q <= cur;
    end
  end

  assign sck_rise = cur[1] & ~prev_q[1];
  assign sck_fall = ~cur[1] & prev_q[1];
  assign cs_high  = cur[2];
  assign cs_rise  = cur[2] & ~prev_q[2];
  assign mosi_s   = cur[0];

endmodule

// File: rtl/slk_cmd_engine.sv
module slk_cmd_engine
  import slk_pkg::*;
#(
  parameter logic [7:0] OPC_WREN = 8'h06,
  parameter logic [7:0] OPC_WRLR = 8'hE5,
  parameter logic [7:0] OPC_RDLR = 8'hE8,
  parameter int         SEC_W    = 6,
  parameter int         SEC_LSB  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             cs_high,
  input  logic             cs_rise,
  input  logic             mosi_s,
  input  logic             busy,
  input  logic [7:0]       rd_byte,
  output logic             wel,
  output logic             wr_stb,
  output logic [SEC_W-1:0] sec,
  output logic [1:0]       wr_bits,
  output logic             miso,
  output logic             miso_oe
);

  localparam int CNT_W = 6;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_OPC  = CNT_W'(OPC_BITS);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_WR);
  localparam int SH_W = ADDR_BITS - 1;

  cmd_e             cmd_q, cmd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic [1:0]       dat_q, dat_d;
  logic             wel_q, wel_d;
  logic             miso_q, miso_d;
  logic             oe_q, oe_d;
  logic [ADDR_BITS-1:0] word_nx;
  logic             commit, wren_hit;

  assign word_nx = {sh_q, mosi_s};

  assign commit   = cs_rise && (cmd_q == CMD_WRLR) && (cnt_q == CNT_FULL)
                    && wel_q && !busy;
  assign wren_hit = cs_rise && (cmd_q == CMD_WREN) && (cnt_q == CNT_OPC);

  always_comb begin
    cmd_d  = cmd_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    sec_d  = sec_q;
    dat_d  = dat_q;
    wel_d  = wel_q;
    miso_d = miso_q;
    oe_d   = oe_q;

    if (cs_high) begin
      cmd_d  = CMD_NONE;
      cnt_d  = '0;
      oe_d   = 1'b0;
      miso_d = 1'b0;
    end else begin
      if (sck_rise) begin
        sh_d = word_nx[SH_W-1:0];
        if ((cmd_q == CMD_RDLR) && (cnt_q == CNT_FULL - 1'b1)) begin
          cnt_d = CNT_HDR;
        end else if (cnt_q != CNT_MAX) begin
          cnt_d = cnt_q + 1'b1;
        end
        if (cnt_q == CNT_OPC - 1'b1) begin
          case (word_nx[7:0])
            OPC_WREN: cmd_d = CMD_WREN;
            OPC_WRLR: cmd_d = CMD_WRLR;
            OPC_RDLR: cmd_d = CMD_RDLR;
            default:  cmd_d = CMD_OTHER;
          endcase
        end
        if (cnt_q == CNT_HDR - 1'b1) begin
          sec_d = word_nx[SEC_LSB +: SEC_W];
        end
        if (cnt_q == CNT_FULL - 1'b1) begin
          dat_d = word_nx[1:0];
        end
      end
      if (sck_fall && (cmd_q == CMD_RDLR) && (cnt_q >= CNT_HDR)) begin
        oe_d   = 1'b1;
        miso_d = rd_byte[3'd7 - cnt_q[2:0]];
      end
    end

    if (commit) begin
      wel_d = 1'b0;
    end else if (wren_hit) begin
      wel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NONE;
      cnt_q  <= '0;
      sh_q   <= '0;
      sec_q  <= '0;
      dat_q  <= '0;
      wel_q  <= 1'b0;
      miso_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      sec_q  <= sec_d;
      dat_q  <= dat_d;
      wel_q  <= wel_d;
      miso_q <= miso_d;
      oe_q   <= oe_d;
    end
  end

  assign wel     = wel_q;
  assign wr_stb  = commit;
  assign sec     = sec_q;
  assign wr_bits = dat_q;
  assign miso    = miso_q;
  assign miso_oe = oe_q;

  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (cmd_q == CMD_RDLR)); // R12
  AST_OE_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> ($past(cnt_q) >= CNT_HDR)); // R10
  AST_WEL_SET_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(cs_rise)); // R2
  AST_OE_DROP_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> !oe_q); // R13

endmodule

// File: rtl/slk_lock_bank.sv
module slk_lock_bank #(
  parameter int NUM_SECT = 64,
  parameter int SEC_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic [SEC_W-1:0]    sec,
  input  logic [1:0]          wr_bits,
  output logic [7:0]          rd_byte,
  output logic [NUM_SECT-1:0] wlock_vec,
  output logic [NUM_SECT-1:0] ldown_vec
);

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
    logic wl_q, wl_d, ld_q, ld_d, hit;

    assign hit = wr_stb && (sec == SEC_W'(i)) && !ld_q;

    always_comb begin
      wl_d = wl_q;
      ld_d = ld_q;
      if (hit) begin
        wl_d = wr_bits[0];
        ld_d = wr_bits[1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wl_q <= 1'b0;
        ld_q <= 1'b0;
      end else begin
        wl_q <= wl_d;
        ld_q <= ld_d;
      end
    end

    assign wlock_vec[i] = wl_q;
    assign ldown_vec[i] = ld_q;

    AST_LOCKDOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_q |=> (ld_q && $stable(wl_q))); // R7
  end

  always_comb begin
    rd_byte = 8'h00;
    if (int'(sec) < NUM_SECT) begin
      rd_byte = {6'b0, ldown_vec[sec], wlock_vec[sec]};
    end
  end

endmodule

// File: rtl/sector_lock_ctrl.sv
module sector_lock_ctrl #(
  parameter int         NUM_SECT    = 64,
  parameter int         SEC_LSB     = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] OPC_WREN    = 8'h06,
  parameter logic [7:0] OPC_WRLR    = 8'hE5,
  parameter logic [7:0] OPC_RDLR    = 8'hE8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_sck,
  input  logic                spi_cs_n,
  input  logic                spi_mosi,
  output logic                spi_miso,
  output logic                spi_miso_oe,
  input  logic                pe_busy,
  output logic                wel,
  output logic [NUM_SECT-1:0] pe_inhibit
);

  localparam int SEC_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;

  logic [1:0] rst_pipe_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_i_n = rst_pipe_q[1];

  logic sck_rise, sck_fall, cs_high, cs_rise, mosi_s;
  logic wr_stb;
  logic [SEC_W-1:0] sec;
  logic [1:0] wr_bits;
  logic [7:0] rd_byte;
  logic [NUM_SECT-1:0] ldown_vec;

  slk_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .sck      (spi_sck),
    .cs_n     (spi_cs_n),
    .mosi     (spi_mosi),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_high  (cs_high),
    .cs_rise  (cs_rise),
    .mosi_s   (mosi_s)
  );

  slk_cmd_engine #(
    .OPC_WREN (OPC_WREN),
    .OPC_WRLR (OPC_WRLR),
    .OPC_RDLR (OPC_RDLR),
    .SEC_W    (SEC_W),
    .SEC_LSB  (SEC_LSB)
  ) i_engine (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_high  (cs_high),
    .cs_rise  (cs_rise),
    .mosi_s   (mosi_s),
    .busy     (pe_busy),
    .rd_byte  (rd_byte),
    .wel      (wel),
    .wr_stb   (wr_stb),
    .sec      (sec),
    .wr_bits  (wr_bits),
    .miso     (spi_miso),
    .miso_oe  (spi_miso_oe)
  );

  slk_lock_bank #(
    .NUM_SECT (NUM_SECT),
    .SEC_W    (SEC_W)
  ) i_bank (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_stb    (wr_stb),
    .sec       (sec),
    .wr_bits   (wr_bits),
    .rd_byte   (rd_byte),
    .wlock_vec (pe_inhibit),
    .ldown_vec (ldown_vec)
  );

  AST_LOCK_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((pe_inhibit != $past(pe_inhibit)) || (ldown_vec != $past(ldown_vec)))
      |-> ($past(wel) && !$past(pe_busy))); // R5 R6
  AST_WEL_CLEARS_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pe_inhibit != $past(pe_inhibit)) |-> !wel); // R3

endmodule

// File: tb/test_sector_lock_ctrl.sv
module test_sector_lock_ctrl;

  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spi_sck, spi_cs_n, spi_mosi, pe_busy;
  logic        spi_miso, spi_miso_oe, wel;
  logic [63:0] pe_inhibit;

  sector_lock_ctrl i_sector_lock_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sck     (spi_sck),
    .spi_cs_n    (spi_cs_n),
    .spi_mosi    (spi_mosi),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .pe_busy     (pe_busy),
    .wel         (wel),
    .pe_inhibit  (pe_inhibit)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_q[$];
  logic [63:0] m_wl, m_ld;
  logic m_wel;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    @(negedge clk);
    chk(wel === m_wel, req, "wel", {63'b0, wel}, {63'b0, m_wel});
    chk(pe_inhibit === m_wl, req, "inhibit", pe_inhibit, m_wl);
  endtask

  task automatic spi_bit(input logic b);
    @(negedge clk) spi_mosi = b;
    repeat (HALF) @(negedge clk);
    spi_sck = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) spi_bit(b[i]);
  endtask

  task automatic cs_begin();
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic xfer_wren(input logic [7:0] opc);
    cs_begin();
    spi_byte(opc);
    cs_end();
    if (opc == 8'h06) m_wel = 1'b1;
  endtask

  task automatic xfer_write(input logic [23:0] addr, input logic [7:0] data,
                            input int nbits);
    int s;
    s = int'(addr[21:16]);
    cs_begin();
    spi_byte(8'hE5);
    for (int i = 23; i >= 0; i--) spi_bit(addr[i]);
    for (int i = 0; i < nbits; i++) spi_bit(data[7 - (i % 8)]);
    cs_end();
    if (nbits == 8 && m_wel && !pe_busy) begin
      if (!m_ld[s]) begin
        m_wl[s] = data[0];
        m_ld[s] = data[1];
      end
      m_wel = 1'b0;
    end
  endtask

  task automatic xfer_read(input logic [23:0] addr, input int nbytes,
                           input int extra);
    int s;
    s = int'(addr[21:16]);
    for (int k = 0; k < nbytes; k++) exp_q.push_back({6'b0, m_ld[s], m_wl[s]});
    cs_begin();
    spi_byte(8'hE8);
    for (int i = 23; i >= 0; i--) spi_bit(addr[i]);
    for (int i = 0; i < 8 * nbytes + extra; i++) spi_bit(1'b0);
    cs_end();
  endtask

  // Monitor: high impedance during header, bytes compared against queue
  int         mon_edge = 0;
  int         mon_nb = 0;
  bit         mon_bad = 1'b0;
  logic [7:0] mon_acc = 8'h00;
  logic [7:0] mon_exp;

  initial begin
    forever begin
      @(posedge spi_sck or posedge spi_cs_n);
      if (spi_cs_n) begin
        if (mon_edge > 0)
          chk(!mon_bad, "R10", "data-out enabled during header", {63'b0, mon_bad}, 64'd0);
        mon_edge = 0;
        mon_nb   = 0;
        mon_bad  = 1'b0;
      end else begin
        mon_edge++;
        if (mon_edge <= 32) begin
          if (spi_miso_oe) mon_bad = 1'b1;
        end else if (spi_miso_oe) begin
          mon_acc = {mon_acc[6:0], spi_miso};
          mon_nb++;
          if (mon_nb == 8) begin
            mon_nb = 0;
            if (exp_q.size() == 0) begin
              chk(1'b0, "R11", "unexpected read byte", {56'b0, mon_acc}, 64'd0);
            end else begin
              mon_exp = exp_q.pop_front();
              chk(mon_acc === mon_exp, "R10", "read byte", {56'b0, mon_acc}, {56'b0, mon_exp});
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run did not finish", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    spi_sck = 1'b0;
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    pe_busy = 1'b0;
    m_wl = '0;
    m_ld = '0;
    m_wel = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check_state("R1");
    chk(spi_miso_oe === 1'b0, "R1", "miso_oe", {63'b0, spi_miso_oe}, 64'd0);
    xfer_read(24'h000000, 1, 0);

    // R2 write enable
    xfer_wren(8'h06);
    check_state("R2");

    // R3 R9 commit with reserved bits set, then read back with zeros
    xfer_write(24'h051234, 8'hFD, 8);
    check_state("R3");
    chk(pe_inhibit[5] === 1'b1, "R9", "inhibit[5]", {63'b0, pe_inhibit[5]}, 64'd1);
    xfer_read(24'h05ABCD, 1, 0);

    // R5 write without latch
    xfer_write(24'h060000, 8'h01, 8);
    check_state("R5");

    // R4 early and late chip-select rise
    xfer_wren(8'h06);
    xfer_write(24'h060000, 8'h01, 7);
    check_state("R4");
    xfer_write(24'h060000, 8'h01, 9);
    check_state("R4");

    // R8 upper address bits ignored
    xfer_write(24'hC60000, 8'h01, 8);
    check_state("R8");
    chk(pe_inhibit[6] === 1'b1, "R8", "inhibit[6]", {63'b0, pe_inhibit[6]}, 64'd1);

    // R6 busy blocks the write and keeps the latch
    xfer_wren(8'h06);
    @(negedge clk) pe_busy = 1'b1;
    xfer_write(24'h070000, 8'h03, 8);
    check_state("R6");
    @(negedge clk) pe_busy = 1'b0;

    // R7 lock-down freezes both bits
    xfer_write(24'h070000, 8'h03, 8);
    check_state("R7");
    xfer_wren(8'h06);
    xfer_write(24'h070000, 8'h00, 8);
    check_state("R7");
    xfer_read(24'h070000, 1, 0);

    // R9 clearing a write lock drops the inhibit
    xfer_wren(8'h06);
    xfer_write(24'h050000, 8'h00, 8);
    check_state("R9");

    // R11 read repeats the byte
    xfer_read(24'h060000, 3, 0);

    // R12 unknown opcode ignored
    xfer_wren(8'h06);
    cs_begin();
    spi_byte(8'h9F);
    for (int i = 0; i < 40; i++) spi_bit(1'b1);
    cs_end();
    check_state("R12");
    xfer_wren(8'h07);
    check_state("R12");

    // R13 read aborted mid byte, then a fresh frame decodes
    cs_begin();
    spi_byte(8'hE8);
    for (int i = 23; i >= 0; i--) spi_bit(1'b0);
    for (int i = 0; i < 4; i++) spi_bit(1'b0);
    cs_end();
    chk(spi_miso_oe === 1'b0, "R13", "miso_oe after cs high", {63'b0, spi_miso_oe}, 64'd0);
    xfer_write(24'h090000, 8'h01, 8);
    check_state("R13");
    chk(pe_inhibit[9] === 1'b1, "R13", "inhibit[9]", {63'b0, pe_inhibit[9]}, 64'd1);

    // R7 only reset clears lock-down
    @(negedge clk) rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    m_wl = '0;
    m_ld = '0;
    m_wel = 1'b0;
    check_state("R7");
    xfer_wren(8'h06);
    xfer_write(24'h070000, 8'h01, 8);
    check_state("R7");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "read bytes not received", exp_q.size(), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule